// File: doc/BRIEF.md
# Chopping-Clock Pulse Gating Synapse

This block scales a presynaptic pulse stream by a stored digital weight held in sign-magnitude form. A free-running phase counter inside the block is decoded into a set of non-overlapping gate windows. Each magnitude bit owns one window, and the windows are binary weighted: the most significant bit's window is open in half of all cycles, the next bit's in a quarter, and so on. The phase counter runs on its own and does not follow the presynaptic pulses, so over time a share of pulses equal to the magnitude fraction gets through.

A pulse that falls inside an open window of a set magnitude bit is passed on. The sign bit decides which of two output lines carries it: the excitatory line or the inhibitory line. The line that is not selected stays low. Pulse passing is combinational from the presynaptic input within the cycle, while the windows change only on clock edges.

Top module: `chop_synapse`

## Requirements
- R1: `weight_i` is sign-magnitude: bit MAG_W is the sign (0 = excitatory, 1 = inhibitory) and bits MAG_W-1:0 are the magnitude, bit MAG_W-1 the most significant.
- R2: The window for magnitude bit k is open when phase bits [j:0] equal 2^j, where j = MAG_W-1-k (with MAG_W=4: bit 3 opens on phase[0]=1, bit 2 on phase[1:0]=10, bit 1 on phase[2:0]=100, bit 0 on phase[3:0]=1000).
- R3: At most one window is open in any cycle, and none is open at phase 0.
- R4: The phase counter is 0 out of reset, advances by one on every clock edge and wraps at 2^MAG_W.
- R5: A pulse passes in a cycle only when `pre_i` is high and the open window belongs to a magnitude bit that is set; the output follows `pre_i` within the same cycle.
- R6: A passed pulse appears on `exc_o` when the sign is 0 and on `inh_o` when it is 1; the other output stays low.
- R7: A magnitude of zero blocks every pulse on both outputs.
- R8: With `pre_i` held high for 2^MAG_W consecutive cycles, the number of passing cycles equals the magnitude.
- R9: While `rst_ni` is low both outputs are low and the phase is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock driving the phase counter |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_i | input | 1 | Presynaptic pulse level |
| weight_i | input | MAG_W+1 | Sign-magnitude weight |
| exc_o | output | 1 | Excitatory pulse output |
| inh_o | output | 1 | Inhibitory pulse output |

## Verification
The bench sweeps every weight, both signs, every phase and both pulse levels, so a window decoded on the wrong bit pattern or with an off-by-one phase shows up as a pulse passed or dropped at one specific phase. Counting passing cycles across a full phase period catches windows that overlap or have the wrong binary weight, which would give a count other than the magnitude. The zero-phase slot and the zero magnitude are checked so that a decoder that opens a window at phase 0, or a router that leaks onto the unselected line, is caught. Reset is checked with the pulse and a full weight applied, which catches outputs that are not gated while the counter is held.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;
  typedef enum logic {
    CH_EXC = 1'b0,
    CH_INH = 1'b1
  } chan_e;
endpackage

// File: rtl/chop_phase_cnt.sv
`timescale 1ns/1ps
module chop_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] phase_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + ONE;
      seen_q <= 1'b1;
    end
  end

  assign phase_o = cnt_q;

  assert_phase_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/chop_window_dec.sv
`timescale 1ns/1ps
module chop_window_dec #(
  parameter int MAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] phase_i,
  output logic [MAG_W-1:0] win_o
);
  // bit k opens when phase[j:0] == 1 followed by j zeros, j = MAG_W-1-k
  for (genvar k = 0; k < MAG_W; k++) begin : g_win
    localparam int J = MAG_W - 1 - k;
    localparam logic [J:0] PAT = (J+1)'(1 << J);
    assign win_o[k] = (phase_i[J:0] == PAT);
  end

  assert_windows_disjoint_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_o));
  assert_zero_slot_closed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == '0) |-> (win_o == '0));
endmodule

// File: rtl/chop_router.sv
`timescale 1ns/1ps
module chop_router
  import chop_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic             pre_i,
  input  logic [MAG_W-1:0] win_i,
  input  logic [MAG_W-1:0] mag_i,
  input  chan_e            chan_i,
  output logic             exc_o,
  output logic             inh_o
);
  logic hit;

  assign hit   = pre_i && |(win_i & mag_i);
  assign exc_o = hit && (chan_i == CH_EXC);
  assign inh_o = hit && (chan_i == CH_INH);
endmodule

// File: rtl/chop_synapse.sv
`timescale 1ns/1ps
module chop_synapse
  import chop_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_i,
  input  logic [MAG_W:0]   weight_i,
  output logic             exc_o,
  output logic             inh_o
);
  localparam int SIGN_BIT = MAG_W;

  logic [MAG_W-1:0] phase;
  logic [MAG_W-1:0] win;
  logic [MAG_W-1:0] mag;
  chan_e            chan;

  assign mag  = weight_i[MAG_W-1:0];
  assign chan = chan_e'(weight_i[SIGN_BIT]);

  chop_phase_cnt #(.CNT_W(MAG_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase)
  );

  chop_window_dec #(.MAG_W(MAG_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .win_o   (win)
  );

  chop_router #(.MAG_W(MAG_W)) u_rt (
    .pre_i  (pre_i),
    .win_i  (win),
    .mag_i  (mag),
    .chan_i (chan),
    .exc_o  (exc_o),
    .inh_o  (inh_o)
  );

  assert_out_needs_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o || inh_o) |-> pre_i);
  assert_unselected_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (weight_i[SIGN_BIT] ? !exc_o : !inh_o));
  assert_zero_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag == '0) |-> (!exc_o && !inh_o));
endmodule

// File: tb/chop_synapse_test.sv
`timescale 1ns/1ps
module chop_synapse_test;
  localparam int MAG_W = 4;
  localparam int NPH   = 1 << MAG_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pre = 1'b0;
  logic [MAG_W:0]   weight = '0;
  logic             exc, inh;
  int               checks = 0;
  int               fails = 0;
  bit               done = 1'b0;
  int               mph = 0;

  always #4 clk = ~clk;

  chop_synapse #(.MAG_W(MAG_W)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pre_i    (pre),
    .weight_i (weight),
    .exc_o    (exc),
    .inh_o    (inh)
  );

  // phase model per R4
  always @(posedge clk or negedge rst_n)
    if (!rst_n) mph <= 0;
    else        mph <= (mph + 1) % NPH;

  // window rule per R2, gating per R5
  function automatic bit gate_open(int m, int ph);
    for (int k = 0; k < MAG_W; k++) begin
      int j;
      j = MAG_W - 1 - k;
      if (((m >> k) & 1) != 0 && (ph % (2 << j)) == (1 << j)) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b weight=%0h phase=%0d pre=%0b",
               req, what, act, exp, weight, mph, pre);
    end
  endtask

  task automatic chk_outs(string req);
    bit e_exp, i_exp, hit;
    hit   = pre && gate_open(int'(weight[MAG_W-1:0]), mph);
    e_exp = hit && !weight[MAG_W];
    i_exp = hit &&  weight[MAG_W];
    chk(req, exc, e_exp, "exc_o");
    chk(req, inh, i_exp, "inh_o");
  endtask

  initial begin
    // R9: held in reset with pulse and full weight
    pre = 1'b1;
    for (int s = 0; s < 2; s++) begin
      weight = {s[0], {MAG_W{1'b1}}};
      repeat (2) @(negedge clk);
      #1;
      chk("R9", exc, 1'b0, "exc_o in reset");
      chk("R9", inh, 1'b0, "inh_o in reset");
    end
    pre = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R5 R6 R7: full sweep of weight x phase x pulse level
    for (int w = 0; w < 2 * NPH; w++) begin
      int passed;
      passed = 0;
      weight = (MAG_W+1)'(w);
      for (int c = 0; c < NPH; c++) begin
        string tag;
        if ((w % NPH) == 0) tag = "R7";
        else if (mph == 0) tag = "R3";
        else if (w >= NPH) tag = "R6";
        else tag = "R2";
        pre = 1'b0;
        #1;
        chk("R5", exc, 1'b0, "exc_o without pulse");
        chk("R5", inh, 1'b0, "inh_o without pulse");
        pre = 1'b1;
        #1;
        chk_outs(tag);
        if (weight[MAG_W] ? inh : exc) passed++;
        @(negedge clk);
      end
      // R8: pass count over one phase period equals magnitude
      checks++;
      if (passed != (w % NPH)) begin
        fails++;
        $display("FAIL R8 pass count weight=%0h: actual=%0d expected=%0d",
                 weight, passed, w % NPH);
      end
    end

    // R4 R9: reset mid-run returns phase to 0 (MSB window closed, then open)
    weight = {1'b0, 1'b1, {(MAG_W-1){1'b0}}};
    pre = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", exc, 1'b0, "exc_o after reset asserted");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R4", exc, 1'b0, "exc_o at phase 0");
    @(negedge clk);
    #1;
    chk("R4", exc, 1'b1, "exc_o at phase 1");
    pre = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule